// File: doc/BRIEF.md
# PHY Management Register Override

This block keeps two management registers of an Ethernet PHY: the control register (address 0) and the auto-negotiation advertisement register (address 4). A simple write port updates them the way a serial management access would. Separate parallel configuration vectors, each with its own strobe, can also overwrite them. A vector is taken only on the clock edge where its strobe is first seen high. After that the management port is free to change the register again until the strobe has gone low and come back high.

A restart strobe requests a fresh auto-negotiation. It raises the restart bit of the control register for exactly one cycle, so the negotiation engine sees a single-cycle pulse. The completion output depends on the build parameter `HAS_MGMT`:

- With a management interface, the output is a latched interrupt with an enable and a write-to-clear bit in an interrupt control register. The completion engine has the states WAIT and PEND. WAIT moves to PEND on a completion rising edge. PEND moves back to WAIT on a clear write.
- Without a management interface, the output follows the completion status. The completion engine has the states OFF and ON. OFF moves to ON when completion is high and no restart pulse is present. ON moves to OFF when completion drops or a restart pulse appears.

All inputs and outputs are synchronous to the single core clock.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the control register reads 16'h1000 (auto-negotiation enable, bit 12, set), the advertisement register reads ADV_RST (default 16'h0020), and `an_irq` is low.
- R2: With `HAS_MGMT`=1, a write with `wr_en` high stores `wr_data` into the control register when `wr_addr`=0, or into the advertisement register when `wr_addr`=4. The new value is visible after that clock edge. A write to any other address changes neither register.
- R3: On a rising edge of `cfg_stb`, the bits of `cfg_vec` are loaded into the control register as follows. All other control bits keep their values.
  - `cfg_vec[0]` goes to bit 5 (unidirectional enable).
  - `cfg_vec[1]` goes to bit 14 (loopback).
  - `cfg_vec[2]` goes to bit 11 (power-down).
  - `cfg_vec[3]` goes to bit 10 (isolate).
  - `cfg_vec[4]` goes to bit 12 (auto-negotiation enable).
- R4: On a rising edge of `adv_stb`, the whole `adv_vec` is loaded into the advertisement register.
- R5: While a strobe stays high, its vector is not loaded again, even if the vector changes. Management writes made in those cycles take effect.
- R6: When a strobe rising edge and a management write hit the same register in the same cycle, the vector load wins and the whole write is discarded.
- R7: A rising edge of `restart_stb`, or an accepted control write with `wr_data[9]`=1, sets control bit 9 for exactly one cycle. A strobe held high does not set it again.
- R8: With `HAS_MGMT`=1, a rising edge of `an_done` latches a pending interrupt. `an_irq` equals pending AND enable, and is visible after that edge.
- R9: With `HAS_MGMT`=1, a write to address 16 does two things:
  - `wr_data[0]` sets the interrupt enable (reset value 1).
  - `wr_data[1]`=1 clears the pending interrupt.
  A pending interrupt is kept while the enable is low, and shows on `an_irq` once the enable is set again.
- R10: With `HAS_MGMT`=0, `an_irq` goes high one edge after `an_done` is sampled high. It goes low one edge after `an_done` is sampled low, or after the restart pulse on control bit 9 appears. The write port has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Management write enable |
| wr_addr | input | ADDR_W | Management register address |
| wr_data | input | 16 | Management write data |
| cfg_vec | input | 5 | Parallel control settings |
| cfg_stb | input | 1 | Load strobe for `cfg_vec`, rising-edge active |
| adv_vec | input | 16 | Parallel advertisement value |
| adv_stb | input | 1 | Load strobe for `adv_vec`, rising-edge active |
| restart_stb | input | 1 | Negotiation restart request, rising-edge active |
| an_done | input | 1 | Negotiation complete status from the engine |
| reg0_q | output | 16 | Control register contents |
| reg4_q | output | 16 | Advertisement register contents |
| an_irq | output | 1 | Completion interrupt or level |

## Verification
Every result of this block is due at the first rising clock edge that samples the stimulus:

- register loads and writes,
- the restart bit,
- the interrupt latch and clear,
- the level follower.

The restart bit falls again one edge later. A restart seen by the level variant takes one more edge, because that variant reacts to the registered bit 9. The bench changes inputs on the falling edge and compares outputs on the next falling edge, so each check lands exactly one edge after its stimulus. For the restart case the bench walks the pulse and its aftermath edge by edge. Two instances, one per `HAS_MGMT` value, share the stimulus, so every write also exercises the ignored-write behaviour of the level variant.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam int REG_W = 16;
    localparam int CFG_W = 5;

    // strobe lanes fed to the shared rising-edge detector
    localparam int N_STB    = 4;
    localparam int STB_CFG  = 0;
    localparam int STB_ADV  = 1;
    localparam int STB_RST  = 2;
    localparam int STB_DONE = 3;

    // control register bit positions
    localparam int B_UNIDIR  = 5;
    localparam int B_RESTART = 9;
    localparam int B_ISO     = 10;
    localparam int B_PWRDN   = 11;
    localparam int B_ANEN    = 12;
    localparam int B_LOOP    = 14;

    localparam logic [REG_W-1:0] CTRL_RST = 16'h1000;

    // vector lane -> control register position
    function automatic int cfg_pos(input int lane);
        case (lane)
            0:       return B_UNIDIR;
            1:       return B_LOOP;
            2:       return B_PWRDN;
            3:       return B_ISO;
            default: return B_ANEN;
        endcase
    endfunction

    typedef enum logic {IRQ_WAIT, IRQ_PEND} irq_state_t;
    typedef enum logic {LVL_OFF, LVL_ON}    lvl_state_t;

endpackage

// File: rtl/pmr_rise_det.sv
module pmr_rise_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] hist_q;

    // history starts low so a strobe already high counts as an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= level;
    end

    assign rise = level & ~hist_q;
endmodule

// File: rtl/pmr_ctrl_reg.sv
module pmr_ctrl_reg
    import pmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wr_data,
    input  logic [CFG_W-1:0] cfg_vec,
    input  logic             cfg_rise,
    input  logic             restart_rise,
    output logic [REG_W-1:0] reg_q
);
    logic [REG_W-1:0] cfg_mask;
    logic [REG_W-1:0] cfg_bits;
    logic [REG_W-1:0] reg_d;

    // scatter the vector lanes onto their register positions
    always_comb begin
        cfg_mask = '0;
        cfg_bits = '0;
        for (int i = 0; i < CFG_W; i++) begin
            cfg_mask[cfg_pos(i)] = 1'b1;
            cfg_bits[cfg_pos(i)] = cfg_vec[i];
        end
    end

    always_comb begin
        reg_d = reg_q;
        reg_d[B_RESTART] = 1'b0;            // restart bit self-clears
        if (cfg_rise)
            reg_d = (reg_d & ~cfg_mask) | cfg_bits;   // vector edge beats a write
        else if (wr_hit)
            reg_d = wr_data;
        if (restart_rise)
            reg_d[B_RESTART] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= CTRL_RST;
        else        reg_q <= reg_d;
    end
endmodule

// File: rtl/pmr_adv_reg.sv
module pmr_adv_reg
    import pmr_pkg::*;
#(
    parameter logic [REG_W-1:0] RST_VAL = 16'h0020
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] adv_vec,
    input  logic             adv_rise,
    output logic [REG_W-1:0] reg_q
);
    logic [REG_W-1:0] reg_d;

    always_comb begin
        if (adv_rise)    reg_d = adv_vec;
        else if (wr_hit) reg_d = wr_data;
        else             reg_d = reg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= RST_VAL;
        else        reg_q <= reg_d;
    end
endmodule

// File: rtl/pmr_done_fsm.sv
module pmr_done_fsm
    import pmr_pkg::*;
#(
    parameter bit HAS_MGMT   = 1'b1,
    parameter bit IRQ_EN_RST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic an_done,
    input  logic done_rise,
    input  logic ictl_hit,
    input  logic ctl_en,
    input  logic ctl_clr,
    input  logic restart_pulse,
    output logic irq
);
    if (HAS_MGMT) begin : g_latched
        irq_state_t st_q, st_d;
        logic       en_q;
        logic       unused_lat;

        assign unused_lat = ^{an_done, restart_pulse};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= IRQ_WAIT;
                en_q <= IRQ_EN_RST;
            end else begin
                st_q <= st_d;
                if (ictl_hit) en_q <= ctl_en;
            end
        end

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                IRQ_WAIT: if (done_rise) st_d = IRQ_PEND;
                IRQ_PEND: if (ictl_hit && ctl_clr && !done_rise) st_d = IRQ_WAIT;
                default:  st_d = IRQ_WAIT;
            endcase
        end

        always_comb irq = (st_q == IRQ_PEND) && en_q;

    end else begin : g_level
        lvl_state_t st_q, st_d;
        logic       unused_lvl;

        assign unused_lvl = ^{done_rise, ictl_hit, ctl_en, ctl_clr};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= LVL_OFF;
            else        st_q <= st_d;
        end

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                LVL_OFF: if (an_done && !restart_pulse) st_d = LVL_ON;
                LVL_ON:  if (!an_done || restart_pulse) st_d = LVL_OFF;
                default: st_d = LVL_OFF;
            endcase
        end

        always_comb irq = (st_q == LVL_ON);
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import pmr_pkg::*;
#(
    parameter bit               HAS_MGMT   = 1'b1,
    parameter int               ADDR_W     = 5,
    parameter int               ICTL_ADDR  = 16,
    parameter logic [15:0]      ADV_RST    = 16'h0020,
    parameter bit               IRQ_EN_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [4:0]        cfg_vec,
    input  logic              cfg_stb,
    input  logic [15:0]       adv_vec,
    input  logic              adv_stb,
    input  logic              restart_stb,
    input  logic              an_done,
    output logic [15:0]       reg0_q,
    output logic [15:0]       reg4_q,
    output logic              an_irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_ADV  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_ICTL = ADDR_W'(ICTL_ADDR);

    logic [N_STB-1:0] stb_vec;
    logic [N_STB-1:0] rise_vec;
    logic             wr_ok;
    logic             hit_ctrl, hit_adv, hit_ictl;

    assign stb_vec[STB_CFG]  = cfg_stb;
    assign stb_vec[STB_ADV]  = adv_stb;
    assign stb_vec[STB_RST]  = restart_stb;
    assign stb_vec[STB_DONE] = an_done;

    // without a management interface the write port is dead
    assign wr_ok    = HAS_MGMT && wr_en;
    assign hit_ctrl = wr_ok && (wr_addr == A_CTRL);
    assign hit_adv  = wr_ok && (wr_addr == A_ADV);
    assign hit_ictl = wr_ok && (wr_addr == A_ICTL);

    pmr_rise_det #(.N(N_STB)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .level (stb_vec),
        .rise  (rise_vec)
    );

    pmr_ctrl_reg u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit       (hit_ctrl),
        .wr_data      (wr_data),
        .cfg_vec      (cfg_vec),
        .cfg_rise     (rise_vec[STB_CFG]),
        .restart_rise (rise_vec[STB_RST]),
        .reg_q        (reg0_q)
    );

    pmr_adv_reg #(.RST_VAL(ADV_RST)) u_adv (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (hit_adv),
        .wr_data  (wr_data),
        .adv_vec  (adv_vec),
        .adv_rise (rise_vec[STB_ADV]),
        .reg_q    (reg4_q)
    );

    pmr_done_fsm #(.HAS_MGMT(HAS_MGMT), .IRQ_EN_RST(IRQ_EN_RST)) u_done (
        .clk           (clk),
        .rst_n         (rst_n),
        .an_done       (an_done),
        .done_rise     (rise_vec[STB_DONE]),
        .ictl_hit      (hit_ictl),
        .ctl_en        (wr_data[0]),
        .ctl_clr       (wr_data[1]),
        .restart_pulse (reg0_q[B_RESTART]),
        .irq           (an_irq)
    );
endmodule

// File: rtl/pmr_checks.sv
module pmr_checks #(
    parameter bit HAS_MGMT = 1'b1,
    parameter int ADDR_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       wr_data,
    input logic [4:0]        cfg_vec,
    input logic [15:0]       adv_vec,
    input logic [15:0]       reg0_q,
    input logic [15:0]       reg4_q,
    input logic              cfg_rise,
    input logic              adv_rise,
    input logic              rst_rise
);
    logic w0, w4;
    assign w0 = HAS_MGMT && wr_en && (wr_addr == ADDR_W'(0));
    assign w4 = HAS_MGMT && wr_en && (wr_addr == ADDR_W'(4));

    // R3: vector lanes land on their control bits
    a_r3_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rise |=> {reg0_q[12], reg0_q[10], reg0_q[11], reg0_q[14], reg0_q[5]} == $past(cfg_vec));

    // R4: advertisement vector loads whole
    a_r4_adv_load: assert property (@(posedge clk) disable iff (!rst_n)
        adv_rise |=> reg4_q == $past(adv_vec));

    // R5: no edge and no write leaves the advertisement register alone
    a_r5_adv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_rise && !w4) |=> $stable(reg4_q));

    // R6: a colliding write does not reach bits outside the vector
    a_r6_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rise && w0) |=> reg0_q[15] == $past(reg0_q[15]));

    // R7: restart bit lasts a single cycle unless set again
    a_r7_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (reg0_q[9] && !rst_rise && !(w0 && !cfg_rise && wr_data[9])) |=> !reg0_q[9]);
endmodule

bind phy_mgmt_regs pmr_checks #(.HAS_MGMT(HAS_MGMT), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cfg_vec  (cfg_vec),
    .adv_vec  (adv_vec),
    .reg0_q   (reg0_q),
    .reg4_q   (reg4_q),
    .cfg_rise (rise_vec[0]),
    .adv_rise (rise_vec[1]),
    .rst_rise (rise_vec[2])
);

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  cfg_vec = '0;
    logic        cfg_stb = 1'b0;
    logic [15:0] adv_vec = '0;
    logic        adv_stb = 1'b0;
    logic        restart_stb = 1'b0;
    logic        an_done = 1'b0;
    logic [15:0] r0_m, r4_m, r0_n, r4_n;
    logic        irq_m, irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] e0, e4, n0, n4;
    localparam logic [15:0] MASK = 16'h5C20;

    always #10 clk = ~clk;   // 50 MHz

    phy_mgmt_regs #(.HAS_MGMT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_vec(cfg_vec), .cfg_stb(cfg_stb), .adv_vec(adv_vec), .adv_stb(adv_stb),
        .restart_stb(restart_stb), .an_done(an_done),
        .reg0_q(r0_m), .reg4_q(r4_m), .an_irq(irq_m));

    phy_mgmt_regs #(.HAS_MGMT(1'b0)) uut_nm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_vec(cfg_vec), .cfg_stb(cfg_stb), .adv_vec(adv_vec), .adv_stb(adv_stb),
        .restart_stb(restart_stb), .an_done(an_done),
        .reg0_q(r0_n), .reg4_q(r4_n), .an_irq(irq_n));

    function automatic logic [15:0] spread(input logic [4:0] v);
        logic [15:0] r = '0;
        r[5]  = v[0];
        r[14] = v[1];
        r[11] = v[2];
        r[10] = v[3];
        r[12] = v[4];
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        e0 = 16'h1000; e4 = 16'h0020; n0 = e0; n4 = e4;
        chk("R1 reg0", r0_m, e0);
        chk("R1 reg4", r4_m, e4);
        chk("R1 irq", {15'd0, irq_m}, 16'd0);
        chk("R1 reg0 nm", r0_n, n0);
        chk("R1 irq nm", {15'd0, irq_n}, 16'd0);

        // R2 management writes
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 16'hA5A0; step();
        e0 = 16'hA5A0;
        chk("R2 ctrl write", r0_m, e0);
        chk("R10 nm ignores write", r0_n, n0);
        wr_addr = 5'd4; wr_data = 16'h1234; step();
        e4 = 16'h1234;
        chk("R2 adv write", r4_m, e4);
        chk("R10 nm ignores adv write", r4_n, n4);
        wr_addr = 5'd7; wr_data = 16'hFFFF; step();
        chk("R2 other addr reg0", r0_m, e0);
        chk("R2 other addr reg4", r4_m, e4);
        wr_en = 1'b0;

        // R3 sweep every vector value
        for (int v = 0; v < 32; v++) begin
            cfg_vec = 5'(v); cfg_stb = 1'b1; step();
            e0 = (e0 & ~MASK) | spread(5'(v));
            n0 = (n0 & ~MASK) | spread(5'(v));
            chk("R3 cfg load", r0_m, e0);
            chk("R3 cfg load nm", r0_n, n0);
            cfg_stb = 1'b0; step();
            chk("R5 idle after load", r0_m, e0);
        end

        // R5 held strobe
        cfg_vec = 5'h1F; cfg_stb = 1'b1; step();
        e0 = (e0 & ~MASK) | spread(5'h1F);
        n0 = (n0 & ~MASK) | spread(5'h1F);
        chk("R3 cfg load all ones", r0_m, e0);
        cfg_vec = 5'h00; step();
        chk("R5 held no reload", r0_m, e0);
        step();
        chk("R5 held no reload nm", r0_n, n0);
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 16'h0100; step();
        e0 = 16'h0100;
        chk("R5 write while held", r0_m, e0);
        wr_en = 1'b0; cfg_stb = 1'b0; step();
        cfg_vec = 5'h12; cfg_stb = 1'b1; step();
        e0 = (e0 & ~MASK) | spread(5'h12);
        n0 = (n0 & ~MASK) | spread(5'h12);
        chk("R5 re-armed load", r0_m, e0);
        chk("R5 re-armed load nm", r0_n, n0);
        cfg_stb = 1'b0; step();

        // R4 advertisement sweep
        for (int i = 0; i < 16; i++) begin
            adv_vec = (i % 2 == 1) ? ~(16'h1 << i) : (16'h1 << i);
            adv_stb = 1'b1; step();
            e4 = adv_vec; n4 = adv_vec;
            chk("R4 adv load", r4_m, e4);
            chk("R4 adv load nm", r4_n, n4);
            adv_stb = 1'b0; step();
        end
        adv_vec = 16'hBEEF; adv_stb = 1'b1; step();
        e4 = 16'hBEEF;
        adv_vec = 16'h0000; step();
        chk("R5 adv held", r4_m, e4);
        adv_stb = 1'b0; step();

        // R6 collisions
        cfg_vec = 5'h00; cfg_stb = 1'b1; wr_en = 1'b1; wr_addr = 5'd0; wr_data = 16'hFFFF; step();
        e0 = e0 & ~MASK; n0 = n0 & ~MASK;
        chk("R6 ctrl collision", r0_m, e0);
        cfg_stb = 1'b0; wr_en = 1'b0; step();
        adv_vec = 16'h0F0F; adv_stb = 1'b1; wr_en = 1'b1; wr_addr = 5'd4; wr_data = 16'hF0F0; step();
        e4 = 16'h0F0F;
        chk("R6 adv collision", r4_m, e4);
        adv_stb = 1'b0; wr_en = 1'b0; step();

        // R7 restart pulse
        restart_stb = 1'b1; step();
        chk("R7 restart set", r0_m, e0 | 16'h0200);
        chk("R7 restart set nm", r0_n, n0 | 16'h0200);
        step();
        chk("R7 restart cleared", r0_m, e0);
        step();
        chk("R7 held no repeat", r0_m, e0);
        restart_stb = 1'b0;
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 16'h4300; step();
        wr_en = 1'b0;
        chk("R7 write sets bit9", r0_m, 16'h4300);
        step();
        e0 = 16'h4100;
        chk("R7 write bit9 clears", r0_m, e0);
        chk("R10 nm reg0 untouched", r0_n, n0);

        // R8 / R9 / R10 completion output
        an_done = 1'b1; step();
        chk("R8 irq latched", {15'd0, irq_m}, 16'd1);
        chk("R10 level high", {15'd0, irq_n}, 16'd1);
        step();
        chk("R8 irq holds", {15'd0, irq_m}, 16'd1);
        wr_en = 1'b1; wr_addr = 5'd16; wr_data = 16'h0003; step();
        wr_en = 1'b0;
        chk("R9 irq cleared", {15'd0, irq_m}, 16'd0);
        chk("R10 nm ignores clear", {15'd0, irq_n}, 16'd1);
        step();
        chk("R9 stays cleared", {15'd0, irq_m}, 16'd0);
        restart_stb = 1'b1; step();
        chk("R10 before restart pulse seen", {15'd0, irq_n}, 16'd1);
        step();
        chk("R10 restart drops level", {15'd0, irq_n}, 16'd0);
        step();
        chk("R10 level returns", {15'd0, irq_n}, 16'd1);
        chk("R8 no new edge", {15'd0, irq_m}, 16'd0);
        restart_stb = 1'b0;
        an_done = 1'b0; step();
        chk("R10 level follows low", {15'd0, irq_n}, 16'd0);
        wr_en = 1'b1; wr_addr = 5'd16; wr_data = 16'h0000; step();
        wr_en = 1'b0;
        an_done = 1'b1; step();
        chk("R9 masked pending", {15'd0, irq_m}, 16'd0);
        chk("R10 level high again", {15'd0, irq_n}, 16'd1);
        wr_en = 1'b1; wr_data = 16'h0001; step();
        chk("R9 enable shows pending", {15'd0, irq_m}, 16'd1);
        wr_data = 16'h0003; step();
        wr_en = 1'b0;
        chk("R9 clear again", {15'd0, irq_m}, 16'd0);

        finish_run();
    end
endmodule